// File: doc/BRIEF.md
# I2C Target with Register Bank and ID Channel

This block is a target (slave) on a two-wire I2C bus. The system clock samples both bus lines. The block never drives SDA high. It gives out one active-high enable, and the pad uses that enable to pull an open-drain SDA line low. The block responds to one fixed 7-bit address. A write transaction first carries a sub-address byte and then data bytes. A read transaction returns data at once, starting where the previous access stopped. The sub-address steps through a wrapping bank of eight 8-bit registers.

A sub-address byte of exactly zero opens a second channel. While that channel is open, reads return a constant eight-byte identification string, and written bytes appear on an 8-bit parallel output port. The block raises a one-cycle pulse when a stop condition ends a message in which it was addressed. A host uses that pulse to act on the bytes it has just received.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 7'h6B (byte 0xD6 with bit 0 masked). Bit 0 selects the direction: 0 means the master writes and 1 means the master reads.
- R2: A byte with any other address gets no acknowledge. After it, SDA is left alone, registers and port are untouched, and no stop pulse follows until the next start condition.
- R3: In a write, the first byte after the address is the sub-address. Each following byte is acknowledged and stored at the current sub-address.
- R4: A read has no sub-address phase. Data goes out MSB first from the current sub-address, and each bit is placed on SDA only while SCL is low.
- R5: Only the low three bits of the sub-address select a register, so 0x08 reaches register 0. The sub-address advances by one after every data byte, read or written, and wraps from 7 to 0.
- R6: A sub-address byte of exactly 0x00 opens the ID channel, and any other sub-address byte closes it. While it is open, reads return 0x50, 0x49, 0x43, 0x49, 0x32, 0x43, 0x00, 0x00, indexed by the sub-address.
- R7: While the ID channel is open, written data bytes go to the parallel port and not to the registers. The port resets to 0xFF. It takes a new byte on the fourth clock edge after SCL rises for that byte's last bit.
- R8: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A repeated start without a stop restarts address reception.
- R9: The message-done output pulses high for exactly one cycle, on the third clock edge after the SDA rise of a stop. It pulses only if this target was addressed since the last start.
- R10: The pull-low enable rises on the third clock edge after SCL falls at the end of an accepted byte. It falls on the third edge after the ninth SCL fall. It changes only while SCL is low.
- R11: During a read, a high level on the master's acknowledge bit ends the transfer. The target then leaves SDA released until a new start.
- R12: Under reset the pull-low enable is 0, the done pulse is 0 and the port is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low through the open-drain pad |
| port_o | output | 8 | Parallel port written through the ID channel |
| msg_done_o | output | 1 | One-cycle pulse at the stop of an addressed message |

## Verification
A fault in the sub-address or the channel flag first shows in the MSB of the next byte read: it is wrong on SDA three cycles after the preceding ninth SCL fall. A fault in the write path reaches the port four cycles after the last data bit rises, or shows up at the next readback. A protocol state that is out of step shows within one bit time, as a pull-low enable that is present or missing in the wrong SCL phase. For this reason the bench compares the pull enable, the port and the done pulse against its own model on every clock. It also reads every stored value back over the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int ID_LEN = 8;

  typedef enum logic [2:0] {
    T_IDLE,
    T_RX,
    T_ACK_WAIT,
    T_ACK_HOLD,
    T_TX,
    T_MACK,
    T_MACK_FALL
  } tgt_state_e;

  typedef enum logic [1:0] {
    B_ADDR,
    B_SUB,
    B_DATA
  } rx_phase_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

  function automatic logic [BYTE_W-1:0] id_byte(input int idx);
    case (idx % ID_LEN)
      0:       id_byte = 8'h50;
      1:       id_byte = 8'h49;
      2:       id_byte = 8'h43;
      3:       id_byte = 8'h49;
      4:       id_byte = 8'h32;
      5:       id_byte = 8'h43;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic                   scl_s, sda_s;
  logic                   scl_q, sda_q;

  // Bus idles high, so the synchronisers reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_comb begin
    ev_o.scl      = scl_s;
    ev_o.sda      = sda_s;
    ev_o.scl_rise = scl_s & ~scl_q;
    ev_o.scl_fall = ~scl_s & scl_q;
    ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store
  import i2c_tgt_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_reg_i,
  input  logic              wr_port_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  input  logic              rd_id_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] port_o
);

  // Reset-free array: write port synchronous, read asynchronous (LUT RAM).
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_reg_i) mem[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)            port_o <= '1;
    else if (wr_port_i) port_o <= wr_data_i;
  end

  assign rd_data_o = rd_id_i ? id_byte(int'(rd_idx_i)) : mem[rd_idx_i];

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B,
  parameter int         AW       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_ev_t           ev_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     sub_o,
  output logic              id_o,
  output logic              wr_reg_o,
  output logic              wr_port_o,
  output logic [AW-1:0]     wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              pull_o,
  output logic              done_o
);

  localparam logic [2:0] LAST_BIT = 3'd7;

  tgt_state_e        st;
  rx_phase_e         ph;
  logic [2:0]        bitcnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              rd_dir;
  logic              sel;
  logic [BYTE_W-1:0] rx_byte;
  logic              addr_hit;

  assign rx_byte  = {rx_sr, ev_i.sda};
  assign addr_hit = (rx_byte[BYTE_W-1:1] == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      ph        <= B_ADDR;
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rd_dir    <= 1'b0;
      sel       <= 1'b0;
      sub_o     <= '0;
      id_o      <= 1'b0;
      wr_reg_o  <= 1'b0;
      wr_port_o <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      pull_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      wr_reg_o  <= 1'b0;
      wr_port_o <= 1'b0;
      done_o    <= 1'b0;
      if (ev_i.stop) begin
        st     <= T_IDLE;
        pull_o <= 1'b0;
        done_o <= sel;
        sel    <= 1'b0;
      end else if (ev_i.start) begin
        st     <= T_RX;
        ph     <= B_ADDR;
        bitcnt <= '0;
        pull_o <= 1'b0;
        sel    <= 1'b0;
      end else begin
        case (st)
          T_RX: begin
            if (ev_i.scl_rise) begin
              rx_sr  <= rx_byte[BYTE_W-2:0];
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == LAST_BIT) begin
                st <= T_ACK_WAIT;
                case (ph)
                  B_ADDR: begin
                    if (addr_hit) begin
                      sel    <= 1'b1;
                      rd_dir <= rx_byte[0];
                      ph     <= rx_byte[0] ? B_DATA : B_SUB;
                    end else begin
                      st <= T_IDLE;
                    end
                  end
                  B_SUB: begin
                    sub_o <= rx_byte[AW-1:0];
                    id_o  <= (rx_byte == 8'h00);
                    ph    <= B_DATA;
                  end
                  default: begin
                    wr_data_o <= rx_byte;
                    wr_idx_o  <= sub_o;
                    sub_o     <= sub_o + AW'(1);
                    if (id_o) wr_port_o <= 1'b1;
                    else      wr_reg_o  <= 1'b1;
                  end
                endcase
              end
            end
          end
          T_ACK_WAIT: begin
            if (ev_i.scl_fall) begin
              pull_o <= 1'b1;
              st     <= T_ACK_HOLD;
            end
          end
          T_ACK_HOLD, T_MACK_FALL: begin
            if (ev_i.scl_fall) begin
              bitcnt <= '0;
              if (rd_dir) begin
                tx_sr  <= rd_data_i;
                pull_o <= ~rd_data_i[BYTE_W-1];
                sub_o  <= sub_o + AW'(1);
                st     <= T_TX;
              end else begin
                pull_o <= 1'b0;
                st     <= T_RX;
              end
            end
          end
          T_TX: begin
            if (ev_i.scl_fall) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == LAST_BIT) begin
                pull_o <= 1'b0;
                st     <= T_MACK;
              end else begin
                pull_o <= ~tx_sr[BYTE_W-2];
                tx_sr  <= tx_sr << 1;
              end
            end
          end
          T_MACK: begin
            if (ev_i.scl_rise) st <= ev_i.sda ? T_IDLE : T_MACK_FALL;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6B,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] port_o,
  output logic              msg_done_o
);

  localparam int AW = $clog2(NUM_REGS);

  bus_ev_t           bus_ev;
  logic [AW-1:0]     sub_idx;
  logic              id_sel;
  logic              wr_reg, wr_port;
  logic [AW-1:0]     wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (bus_ev)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (bus_ev),
    .rd_data_i (rd_data),
    .sub_o     (sub_idx),
    .id_o      (id_sel),
    .wr_reg_o  (wr_reg),
    .wr_port_o (wr_port),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .pull_o    (sda_pull_o),
    .done_o    (msg_done_o)
  );

  i2c_reg_store #(.DEPTH(NUM_REGS)) i_store (
    .clk       (clk),
    .rst       (rst),
    .wr_reg_i  (wr_reg),
    .wr_port_i (wr_port),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (sub_idx),
    .rd_id_i   (id_sel),
    .rd_data_o (rd_data),
    .port_o    (port_o)
  );

endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker
  import i2c_tgt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input bus_ev_t           ev,
  input logic              pull,
  input logic              done,
  input logic [BYTE_W-1:0] port
);

  // R10: the pull enable only moves while the sampled clock is low
  p_pull_low_phase_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull) |-> !ev.scl);

  // R9: the done pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: the done pulse follows a detected stop
  p_done_after_stop_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ev.stop));

  // R7: the port changes only two edges after a sampled clock rise
  p_port_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(port) |-> $past(ev.scl_rise, 2));

  // R12: reset value of the port
  p_port_reset_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (port == 8'hFF));

endmodule

bind i2c_regbank_target i2c_regbank_checker i_chk (
  .clk  (clk),
  .rst  (rst),
  .ev   (bus_ev),
  .pull (sda_pull_o),
  .done (msg_done_o),
  .port (port_o)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;

  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam int LAT   = 3;
  localparam int PLAT  = 4;
  localparam int WD    = 150000;
  localparam logic [6:0] ME = 7'h6B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic pull, done;
  logic [7:0] port;

  assign sda_line = m_sda & ~pull;

  i2c_regbank_target i_i2c_regbank_target (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (pull),
    .port_o     (port),
    .msg_done_o (done)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural model
  logic [7:0] m_regs [8];
  int         m_sub = 0;
  bit         m_id  = 0;
  logic [7:0] id_str [8] = '{8'h50, 8'h49, 8'h43, 8'h49, 8'h32, 8'h43, 8'h00, 8'h00};

  logic [7:0] e_port = 8'hFF;
  logic       e_pull = 1'b0;
  logic       e_done = 1'b0;
  int         c_port = 0, c_pull = 0, c_done = 0;
  logic [7:0] n_port = 8'hFF;
  logic       n_pull = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      e_port = 8'hFF; e_pull = 1'b0; e_done = 1'b0;
      c_port = 0; c_pull = 0; c_done = 0;
    end else begin
      if (c_pull > 0) begin c_pull--; if (c_pull == 0) e_pull = n_pull; end
      if (c_port > 0) begin c_port--; if (c_port == 0) e_port = n_port; end
      e_done = 1'b0;
      if (c_done > 0) begin c_done--; if (c_done == 0) e_done = 1'b1; end
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model (R10, R7, R9)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10", "pull enable", {7'd0, pull}, {7'd0, e_pull});
      chk("R7",  "port",        port, e_port);
      chk("R9",  "done pulse",  {7'd0, done}, {7'd0, e_done});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sched_pull(logic v);
    n_pull = v; c_pull = LAT;
  endtask

  function automatic logic [7:0] m_rd(int s);
    return m_id ? id_str[s % 8] : m_regs[s % 8];
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; idle(Q); m_scl = 1'b1; idle(Q);
    m_sda = 1'b0; idle(Q); m_scl = 1'b0; idle(Q);
  endtask

  task automatic bus_stop(bit exp_done);
    m_sda = 1'b0; idle(Q); m_scl = 1'b1; idle(Q);
    m_sda = 1'b1; if (exp_done) c_done = LAT;
    idle(2*Q);
  endtask

  task automatic wr_byte(logic [7:0] b, bit ack, bit to_port, logic next_pull, string req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(Q); m_scl = 1'b1;
      if (i == 0 && to_port) begin n_port = b; c_port = PLAT; end
      idle(2*Q); m_scl = 1'b0;
      if (i == 0 && ack) sched_pull(1'b1);
      idle(Q);
    end
    m_sda = 1'b1; idle(Q); m_scl = 1'b1; idle(Q);
    chk(req, "acknowledge level", {7'd0, sda_line}, ack ? 8'h00 : 8'h01);
    idle(Q); m_scl = 1'b0;
    if (ack) sched_pull(next_pull);
    idle(Q);
  endtask

  task automatic rd_byte(logic [7:0] exp, bit mack, logic [7:0] nxt, string req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; idle(Q); m_scl = 1'b1; idle(Q);
      chk(req, "read bit", {7'd0, sda_line}, {7'd0, exp[i]});
      idle(Q); m_scl = 1'b0;
      sched_pull(i > 0 ? ~exp[i-1] : 1'b0);
      idle(Q);
    end
    m_sda = mack ? 1'b0 : 1'b1; idle(Q); m_scl = 1'b1; idle(2*Q);
    m_scl = 1'b0;
    if (mack) sched_pull(~nxt[7]);
    idle(Q);
  endtask

  task automatic wr_txn(logic [6:0] a, logic [7:0] sub, logic [7:0] d[$], bit do_stop);
    bit hit;
    hit = (a == ME);
    bus_start();
    wr_byte({a, 1'b0}, hit, 1'b0, 1'b0, hit ? "R1" : "R2");
    if (!hit) begin
      wr_byte(sub, 1'b0, 1'b0, 1'b0, "R2");
      foreach (d[k]) wr_byte(d[k], 1'b0, 1'b0, 1'b0, "R2");
    end else begin
      wr_byte(sub, 1'b1, 1'b0, 1'b0, "R3");
      m_sub = sub % 8;
      m_id  = (sub == 8'h00);
      foreach (d[k]) begin
        if (m_id) wr_byte(d[k], 1'b1, 1'b1, 1'b0, "R7");
        else begin
          m_regs[m_sub] = d[k];
          wr_byte(d[k], 1'b1, 1'b0, 1'b0, "R3");
        end
        m_sub = (m_sub + 1) % 8;
      end
    end
    if (do_stop) bus_stop(hit);
  endtask

  task automatic rd_txn(int n, int extra, string req);
    logic [7:0] first, e, nx;
    bus_start();
    first = m_rd(m_sub);
    wr_byte({ME, 1'b1}, 1'b1, 1'b0, ~first[7], "R1");
    for (int k = 0; k < n; k++) begin
      e = m_rd(m_sub);
      m_sub = (m_sub + 1) % 8;
      nx = m_rd(m_sub);
      rd_byte(e, k < n - 1, nx, req);
    end
    // R11: after the NACK the target leaves SDA released
    for (int j = 0; j < extra; j++) begin
      m_sda = 1'b1; idle(Q); m_scl = 1'b1; idle(Q);
      chk("R11", "line after nack", {7'd0, sda_line}, 8'h01);
      idle(Q); m_scl = 1'b0; idle(Q);
    end
    bus_stop(1'b1);
  endtask

  task automatic run_all();
    logic [7:0] q[$];
    logic [7:0] none[$];
    idle(5);
    rst = 1'b0;
    idle(2);
    chk("R12", "port after reset", port, 8'hFF);
    chk("R12", "pull after reset", {7'd0, pull}, 8'h00);
    chk("R12", "done after reset", {7'd0, done}, 8'h00);

    // R3, R5: fill registers 1..7, sub-address wraps to 0
    q = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    wr_txn(ME, 8'h01, q, 1'b1);
    // R5, R6: sub-address 0x08 reaches register 0, not the ID channel
    q = '{8'h5A};
    wr_txn(ME, 8'h08, q, 1'b1);
    // R4: read continues from sub-address 1
    rd_txn(3, 0, "R4");
    // R7: ID channel writes go to the port
    q = '{8'h3C, 8'hC3};
    wr_txn(ME, 8'h00, q, 1'b1);
    // R6: ID string from index 2, then wrap past index 7
    rd_txn(4, 0, "R6");
    rd_txn(3, 0, "R6");
    // R2: foreign address, bytes ignored, no done pulse
    q = '{8'h11, 8'h22};
    wr_txn(7'h6A, 8'h02, q, 1'b1);
    // R8: set sub-address, repeated start, read across the wrap
    wr_txn(ME, 8'h06, none, 1'b0);
    rd_txn(4, 0, "R8");
    // R11, R2: read 2 (register 2 unchanged by foreign write), then idle clocks
    rd_txn(2, 9, "R2");
    // R5: sub-address advanced by exactly one per byte read
    rd_txn(1, 0, "R5");
    chk("R7", "port keeps last byte", port, 8'hC3);
    idle(10);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD) @(posedge clk);
        checks++; fails++;
        $display("FAIL R-none watchdog actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule